// File: doc/BRIEF.md
# Interrupt Coalescing and Credit Controller

This block produces the interrupt message pulse for one interrupt vector. Device logic raises `event_i` when it needs service. The block sends an interrupt only when three things hold: the vector is unmasked, the coalescing countdown has run out, and an event is either arriving or already latched. Every send reloads the countdown from a programmed start value. The countdown then falls by one on each microsecond tick. Events that arrive while the vector is blocked merge into a single pending flag, and `pend_o` shows that flag.

Software uses a small word-addressed register port. Through it, software sets the mask, the coalescing start value and an auto-mask mode, and reads back the live countdown. A signed credit counter rises by one on every send. A write to the credit word subtracts a count from it in one step. The same write word carries two command bits: one clears the mask, the other restarts the countdown. Setting both rearms the vector. When a credit write leaves the counter at zero, the block drops any interrupt that is pending but not yet sent.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset, the mask reads 1, the coalescing start value, the live countdown and the credit counter read 0, and `irq_o` and `pend_o` are low.
- R2: While the mask is 1, no interrupt is sent. An event that arrives in that state sets `pend_o`.
- R3: In a cycle where the mask is 0, the countdown is 0 and an event is latched or arriving, a send occurs. `irq_o` pulses for one cycle after that clock edge, and the same edge clears `pend_o`.
- R4: With a start value of 0 and the mask at 0, every event produces its own pulse, including events on back-to-back cycles.
- R5: A send loads the countdown with the start value. The countdown falls by one on each `us_tick_i` and stays at zero once it gets there. Events that arrive while it is nonzero send nothing and merge into one pending flag.
- R6: When the countdown reaches zero with an event pending, exactly one interrupt is sent on the next edge.
- R7: When auto-mask (offset 0x08, bit 0) is 1, the mask becomes 1 at every send. This overrides any software write to the mask in the same cycle.
- R8: The credit counter is a 16-bit two's-complement value read at offset 0x00, bits 15:0. It rises by one per send. A write to offset 0x00 subtracts write-data bits 14:0, and bit 15 of the write is ignored.
- R9: A credit write that leaves the counter at zero clears `pend_o` and discards the latched event, so no interrupt follows.
- R10: In a credit write, bit 16 set to 1 clears the mask and bit 17 set to 1 reloads the countdown from the start value. Either bit can be used alone.
- R11: When a send and a credit write fall in the same cycle, both take effect, so the counter changes by one minus the written count.
- R12: The register map is: 0x00 credit/commands, 0x04 mask (bit 0), 0x08 auto-mask (bit 0), 0x0C start value (bits 5:0, upper bits ignored), 0x10 live countdown (read-only). Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| us_tick_i | input | 1 | One-cycle pulse once per microsecond |
| event_i | input | 1 | Interrupt assertion event |
| irq_o | output | 1 | One-cycle interrupt message pulse |
| pend_o | output | 1 | Pending-interrupt status |

## Verification
The assertions check these on every cycle: a masked vector or a running countdown never produces a pulse; every send reloads the countdown, clears the pending flag and, in auto-mask mode, sets the mask; an idle countdown stays at zero; the credit counter moves only by send increments or software writes; and a write that leaves the counter at zero leaves nothing pending. Some behaviour can only be shown by the bench's scenarios, which follow register values through time. These cover the merging of several blocked events into exactly one later pulse, the release of a pending event at the moment the countdown expires, signed wrap of the counter below zero, the net result when a send and a credit write coincide, the separate effects of the two command bits, and the discarding of a pending event when the counter is zeroed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Byte offsets of the control words.
   localparam int OFF_CREDIT = 'h00;
   localparam int OFF_MASK   = 'h04;
   localparam int OFF_AUTO   = 'h08;
   localparam int OFF_INIT   = 'h0C;
   localparam int OFF_CUR    = 'h10;

   // Command bits inside the credit write word (software encodes them).
   localparam int CMD_UNMASK_BIT = 16;
   localparam int CMD_RELOAD_BIT = 17;

   typedef enum logic [2:0] {
      SEL_CREDIT,
      SEL_MASK,
      SEL_AUTO,
      SEL_INIT,
      SEL_CUR,
      SEL_NONE
   } reg_sel_e;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int TIMER_W = 6,
   parameter int CRED_W  = 16,
   parameter int CNT_W   = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                we,
   input  logic                fire,
   input  logic [TIMER_W-1:0]  timer_cur,
   input  logic [CRED_W-1:0]   credit,
   output logic [DATA_W-1:0]   rdata,
   output logic                mask_q,
   output logic                auto_q,
   output logic [TIMER_W-1:0]  init_q,
   output logic                cred_wr,
   output logic [CNT_W-1:0]    cred_dec,
   output logic                cmd_reload
);

   reg_sel_e sel;

   always_comb begin
      if (addr == ADDR_W'(OFF_CREDIT))      sel = SEL_CREDIT;
      else if (addr == ADDR_W'(OFF_MASK))   sel = SEL_MASK;
      else if (addr == ADDR_W'(OFF_AUTO))   sel = SEL_AUTO;
      else if (addr == ADDR_W'(OFF_INIT))   sel = SEL_INIT;
      else if (addr == ADDR_W'(OFF_CUR))    sel = SEL_CUR;
      else                                  sel = SEL_NONE;
   end

   logic cmd_unmask;

   assign cred_wr    = we && (sel == SEL_CREDIT);
   assign cred_dec   = wdata[CNT_W-1:0];
   assign cmd_unmask = cred_wr && wdata[CMD_UNMASK_BIT];
   assign cmd_reload = cred_wr && wdata[CMD_RELOAD_BIT];

   logic mask_d;

   always_comb begin
      mask_d = mask_q;
      if (we && (sel == SEL_MASK)) mask_d = wdata[0];
      if (cmd_unmask)              mask_d = 1'b0;
      if (fire && auto_q)          mask_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
         auto_q <= 1'b0;
         init_q <= '0;
      end else begin
         mask_q <= mask_d;
         if (we && (sel == SEL_AUTO)) auto_q <= wdata[0];
         if (we && (sel == SEL_INIT)) init_q <= wdata[TIMER_W-1:0];
      end
   end

   always_comb begin
      case (sel)
         SEL_CREDIT: rdata = DATA_W'(credit);
         SEL_MASK:   rdata = DATA_W'(mask_q);
         SEL_AUTO:   rdata = DATA_W'(auto_q);
         SEL_INIT:   rdata = DATA_W'(init_q);
         SEL_CUR:    rdata = DATA_W'(timer_cur);
         default:    rdata = '0;
      endcase
   end

   logic unused_wbits;
   assign unused_wbits = ^wdata;

endmodule

// File: rtl/irqc_timer.sv
module irqc_timer #(
   parameter int TIMER_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIMER_W-1:0] init,
   input  logic               load,
   input  logic               tick,
   output logic [TIMER_W-1:0] cur,
   output logic               expired
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cur <= '0;
      else if (load)                 cur <= init;
      else if (tick && cur != '0)    cur <= cur - TIMER_W'(1);
   end

   assign expired = (cur == '0);

endmodule

// File: rtl/irqc_credit.sv
module irqc_credit #(
   parameter int CRED_W = 16,
   parameter int CNT_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_en,
   input  logic [CNT_W-1:0]  dec_amt,
   input  logic              inc,
   output logic [CRED_W-1:0] count,
   output logic              zero_on_wr
);

   logic [CRED_W-1:0] sub_term;
   logic [CRED_W-1:0] count_d;

   assign sub_term   = dec_en ? CRED_W'(dec_amt) : '0;
   assign count_d    = count - sub_term + (inc ? CRED_W'(1) : '0);
   assign zero_on_wr = dec_en && (count_d == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count_d;
   end

endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl #(
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int TIMER_W = 6,
   parameter int CRED_W  = 16,
   parameter int CNT_W   = 15,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   input  logic              reg_we_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              us_tick_i,
   input  logic              event_i,
   output logic              irq_o,
   output logic              pend_o
);

   if (TIMER_W < 1 || TIMER_W > DATA_W) begin : g_bad_timer
      $error("TIMER_W must lie in 1..DATA_W");
   end
   if (CNT_W >= CRED_W) begin : g_bad_cnt
      $error("CNT_W must be narrower than CRED_W");
   end
   if (DATA_W < 18 || CRED_W > DATA_W) begin : g_bad_data
      $error("DATA_W must hold the command bits and the credit word");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x10");
   end

   logic               fire;
   logic               pend_q;
   logic               mask_q;
   logic               auto_q;
   logic [TIMER_W-1:0] init_q;
   logic [TIMER_W-1:0] timer_q;
   logic               timer_zero;
   logic               cred_wr;
   logic [CNT_W-1:0]   cred_dec;
   logic               cmd_reload;
   logic [CRED_W-1:0]  credit_q;
   logic               zero_wr;
   logic               tmr_load;

   irqc_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMER_W(TIMER_W),
      .CRED_W(CRED_W), .CNT_W(CNT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .addr(reg_addr_i), .wdata(reg_wdata_i), .we(reg_we_i),
      .fire(fire), .timer_cur(timer_q), .credit(credit_q),
      .rdata(reg_rdata_o), .mask_q(mask_q), .auto_q(auto_q),
      .init_q(init_q), .cred_wr(cred_wr), .cred_dec(cred_dec),
      .cmd_reload(cmd_reload)
   );

   assign tmr_load = fire || cmd_reload;

   irqc_timer #(.TIMER_W(TIMER_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .init(init_q), .load(tmr_load),
      .tick(us_tick_i), .cur(timer_q), .expired(timer_zero)
   );

   irqc_credit #(.CRED_W(CRED_W), .CNT_W(CNT_W)) u_credit (
      .clk(clk), .rst_n(rst_n), .dec_en(cred_wr), .dec_amt(cred_dec),
      .inc(fire), .count(credit_q), .zero_on_wr(zero_wr)
   );

   assign fire = !mask_q && timer_zero && (pend_q || event_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= !fire && !zero_wr && (pend_q || event_i);
   end

   assign pend_o = pend_q;

   if (REG_OUT) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= fire;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = fire;
   end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int TIMER_W = 6,
   parameter int CRED_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fire,
   input logic               irq_o,
   input logic               mask_q,
   input logic               auto_q,
   input logic [TIMER_W-1:0] timer_q,
   input logic [TIMER_W-1:0] init_q,
   input logic               tmr_load,
   input logic               pend_q,
   input logic [CRED_W-1:0]  credit_q,
   input logic               cred_wr
);

   if (REG_OUT) begin : g_reg
      assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
         mask_q |=> !irq_o);
      assert_timer_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (timer_q != '0) |=> !irq_o);
      assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
         fire |=> irq_o);
   end else begin : g_comb
      assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
         mask_q |-> !irq_o);
      assert_timer_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (timer_q != '0) |-> !irq_o);
   end

   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (timer_q == $past(init_q)));

   assert_stay_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((timer_q == '0) && !tmr_load) |=> (timer_q == '0));

   assert_pend_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !pend_q);

   assert_automask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && auto_q) |=> mask_q);

   assert_credit_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !cred_wr) |=> (credit_q == $past(credit_q) + CRED_W'(1)));

   assert_credit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && !cred_wr) |=> $stable(credit_q));

   assert_zero_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cred_wr |=> ((credit_q != '0) || !pend_q));

endmodule

bind irq_coalesce_ctrl irqc_checker #(
   .TIMER_W(TIMER_W), .CRED_W(CRED_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fire(fire), .irq_o(irq_o),
   .mask_q(mask_q), .auto_q(auto_q), .timer_q(timer_q), .init_q(init_q),
   .tmr_load(tmr_load), .pend_q(pend_q), .credit_q(credit_q),
   .cred_wr(cred_wr)
);

// File: tb/irq_coalesce_ctrl_test.sv
module irq_coalesce_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] A_CRED = 5'h00;
   localparam logic [4:0] A_MASK = 5'h04;
   localparam logic [4:0] A_AUTO = 5'h08;
   localparam logic [4:0] A_INIT = 5'h0C;
   localparam logic [4:0] A_CUR  = 5'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0;
   logic [31:0] rdata;
   logic        tick = 1'b0;
   logic        evt = 1'b0;
   logic        irq;
   logic        pend;

   irq_coalesce_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_we_i(we), .reg_rdata_o(rdata), .us_tick_i(tick),
      .event_i(evt), .irq_o(irq), .pend_o(pend)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          kind;   // 0 irq, 1 pending, 2 read data
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Monitor: consumes expectations at the falling edge.
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = q.pop_front();
         case (it.kind)
            0:       act = {31'b0, irq};
            1:       act = {31'b0, pend};
            default: act = rdata;
         endcase
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
      we = 1'b0; evt = 1'b0; tick = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      cyc();
   endtask

   task automatic exp_irq(input logic e, input string tag);
      item_t it;
      it.kind = 0; it.exp = {31'b0, e}; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic exp_pend(input logic e, input string tag);
      item_t it;
      it.kind = 1; it.exp = {31'b0, e}; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic exp_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
      item_t it;
      addr = a;
      it.kind = 2; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic sample();
      @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      exp_irq(1'b0, "R1 irq"); exp_pend(1'b0, "R1 pend");
      exp_rd(A_MASK, 32'h1, "R1 mask"); sample();
      exp_rd(A_INIT, 32'h0, "R1 init"); sample();
      exp_rd(A_CUR, 32'h0, "R1 cur"); sample();
      exp_rd(A_CRED, 32'h0, "R1 credit"); sample();

      // R2 masked events latch only
      evt = 1'b1; cyc();
      exp_irq(1'b0, "R2 masked irq"); exp_pend(1'b1, "R2 pend set"); sample();
      evt = 1'b1; cyc();
      exp_irq(1'b0, "R2 masked irq again"); exp_rd(A_CRED, 32'h0, "R2 no credit"); sample();

      // R3 unmask releases pending
      wr(A_MASK, 32'h0);
      exp_irq(1'b0, "R3 before send"); exp_pend(1'b1, "R3 still pend"); sample();
      cyc();
      exp_irq(1'b1, "R3 pulse"); exp_pend(1'b0, "R3 pend cleared");
      exp_rd(A_CRED, 32'h1, "R8 credit after send"); sample();
      cyc();
      exp_irq(1'b0, "R3 single pulse"); sample();

      // R4 no coalescing: back-to-back events
      evt = 1'b1; cyc();
      exp_irq(1'b1, "R4 first"); sample();
      evt = 1'b1; cyc();
      exp_irq(1'b1, "R4 second"); sample();
      cyc();
      exp_irq(1'b0, "R4 idle"); exp_rd(A_CRED, 32'h3, "R4 credit 3"); sample();

      // R8 signed credit
      wr(A_CRED, 32'h3);
      exp_rd(A_CRED, 32'h0, "R8 sub to zero"); sample();
      wr(A_CRED, 32'h1);
      exp_rd(A_CRED, 32'h0000_FFFF, "R8 negative"); sample();
      // R11 send and write together
      addr = A_CRED; wdata = 32'h2; we = 1'b1; evt = 1'b1; cyc();
      exp_irq(1'b1, "R11 send"); exp_rd(A_CRED, 32'h0000_FFFE, "R11 net"); sample();
      wr(A_CRED, 32'h0000_8001);
      exp_rd(A_CRED, 32'h0000_FFFD, "R8 bit15 ignored"); sample();

      // R5/R6 coalescing
      wr(A_INIT, 32'h5);
      evt = 1'b1; cyc();
      exp_irq(1'b1, "R5 send"); exp_rd(A_CUR, 32'h5, "R5 loaded"); sample();
      evt = 1'b1; cyc();
      exp_irq(1'b0, "R5 blocked"); exp_pend(1'b1, "R5 pend"); sample();
      evt = 1'b1; cyc();
      exp_pend(1'b1, "R5 merged"); sample();
      for (int i = 0; i < 4; i++) begin
         tick = 1'b1; cyc();
      end
      exp_irq(1'b0, "R5 still blocked"); exp_rd(A_CUR, 32'h1, "R5 count"); sample();
      tick = 1'b1; cyc();
      exp_irq(1'b0, "R6 before"); exp_pend(1'b1, "R6 pend");
      exp_rd(A_CUR, 32'h0, "R6 expired"); sample();
      cyc();
      exp_irq(1'b1, "R6 pulse"); exp_pend(1'b0, "R6 cleared");
      exp_rd(A_CUR, 32'h5, "R5 reload"); sample();
      cyc();
      exp_irq(1'b0, "R6 only one"); exp_rd(A_CRED, 32'h0000_FFFF, "R8 two sends"); sample();
      for (int i = 0; i < 7; i++) begin
         tick = 1'b1; cyc();
      end
      exp_irq(1'b0, "R5 idle"); exp_rd(A_CUR, 32'h0, "R5 saturate"); sample();

      // R7 auto-mask
      wr(A_AUTO, 32'h1);
      evt = 1'b1; cyc();
      exp_irq(1'b1, "R7 send"); exp_rd(A_MASK, 32'h1, "R7 masked"); sample();
      exp_rd(A_CRED, 32'h0, "R8 wrap to zero"); sample();

      // R10 command bits
      tick = 1'b1; cyc();
      tick = 1'b1; cyc();
      exp_rd(A_CUR, 32'h3, "R10 pre"); sample();
      wr(A_CRED, 32'h0002_0000);
      exp_rd(A_CUR, 32'h5, "R10 reload"); sample();
      exp_rd(A_MASK, 32'h1, "R10 reload keeps mask"); sample();
      wr(A_CRED, 32'h0001_0000);
      exp_rd(A_MASK, 32'h0, "R10 unmask"); sample();

      // R9 zeroing credit drops pending
      evt = 1'b1; cyc();
      exp_irq(1'b0, "R9 blocked"); exp_pend(1'b1, "R9 pend"); sample();
      wr(A_CRED, 32'h0);
      exp_pend(1'b0, "R9 dropped"); sample();
      for (int i = 0; i < 5; i++) begin
         tick = 1'b1; cyc();
      end
      exp_irq(1'b0, "R9 no send a"); sample();
      cyc();
      exp_irq(1'b0, "R9 no send b"); exp_rd(A_CRED, 32'h0, "R9 credit"); sample();

      // R12 map details
      exp_rd(5'h14, 32'h0, "R12 unmapped"); sample();
      wr(A_MASK, 32'hFFFF_FFFE);
      exp_rd(A_MASK, 32'h0, "R12 mask bit0"); sample();
      wr(A_INIT, 32'hFFFF_FFC7);
      exp_rd(A_INIT, 32'h7, "R12 init width"); sample();
      exp_rd(A_AUTO, 32'h1, "R12 auto"); sample();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule